// File: doc/BRIEF.md
# Indirect Control/Status Register Window for a Network Controller

This block is the register front end of a network controller. A host sees two 16-bit word ports. One is a pointer port and the other is a data port. The host first writes an index into the pointer port. Accesses to the data port then reach the internal register that the index selects.

There are four internal registers:

- Index 0 is the main control/status word. It holds sticky event bits that the host clears by writing ones, two summary bits that are derived from those events, an interrupt enable, and the init, start and stop commands.
- Indices 1 and 2 hold the low and high halves of a 32-bit pointer to an initialization block in memory. That pointer is driven out continuously.
- Index 3 is a plain mode word that the block stores and returns unchanged.

Other parts of the controller report receive, transmit and error events on a 7-bit event input, one bit per sticky status bit. The interrupt request output is the interrupt flag qualified by the interrupt enable.

Top module: `nic_csr_window`

## Requirements
- R1: The port is chosen by the word index, which is the byte address shifted right by one; address bit 0 is ignored. Word 0 is the data port and word 1 is the pointer port. Every other word reads 0, and writes to it change no state.
- R2: A write to the pointer port loads the pointer only if the written value is below 4. Otherwise the pointer keeps its previous value. Reading the pointer port returns the pointer, zero-extended.
- R3: A write to register 0 with bit 2 set loads register 0 with exactly 0x0004, whatever its other bits are.
- R4: On any other write to register 0, each 1 in bits 14..8 clears the matching sticky bit. A 0 leaves that bit unchanged.
- R5: On such a write, the summary bits are recomputed after the clearing step. Bit 15 is the OR of bits 14, 13, 12 and 8. Bit 7 is the OR of bits 14..8. Bit 8 set by an INIT command in the same write is not included in that recomputation.
- R6: On every write to register 0 that does not stop the block, bit 6 takes the written bit 6.
- R7: On a non-stop write, a 1 in bit 0 sets bits 8 and 0 and clears bit 2. If bit 0 is 0 and bit 1 is 1, the write sets bits 1, 5 and 4 and clears bit 2. When both bits are set, INIT takes precedence.
- R8: The 32-bit initialization pointer output takes register 1 as its bits 15..0 and register 2 as its bits 31..16. Both registers read back what was written to them.
- R9: Register 3 stores all 16 written bits and reads them back.
- R10: After reset, register 0 is 0x0004, the pointer is 0, registers 1 to 3 are 0, and the interrupt output is low.
- R11: The interrupt output is high exactly when bits 7 and 6 of register 0 are both 1.
- R12: In the cycle after an event bit i (0..6) is pulsed, bit 8+i of register 0 and bit 7 are set. Bit 15 is not updated until the next write to register 0. An event that arrives in the same cycle as a write is applied after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Byte address of the access |
| wrEn | input | 1 | Write strobe for the current address |
| wrData | input | 16 | Write data |
| evtSet | input | 7 | Event pulses that set status bits 14..8 |
| rdData | output | 16 | Read data for the current address (combinational) |
| ctrlStatus | output | 16 | Current value of register 0 |
| initPtr | output | 32 | Initialization-block pointer {reg2, reg1} |
| irq | output | 1 | Interrupt request |

## Verification
Reads are combinational, so a read result is due in the same cycle as its address. All register updates, whether from writes or from events, appear one clock edge after the cycle in which the strobe was presented, and the interrupt output follows register 0 with no further delay. The bench therefore drives each input shortly after a rising edge. A write is held for one full cycle, and every expected value is sampled on the following falling edge, after the updating edge has passed. The deferred error summary after an event and the INIT-over-START precedence are checked in the cycles where they become visible.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int DATA_W = 16;
  localparam int EVT_W  = 7;

  localparam int BIT_ERR   = 15;
  localparam int BIT_IFLAG = 7;
  localparam int BIT_IEN   = 6;
  localparam int BIT_RXON  = 5;
  localparam int BIT_TXON  = 4;
  localparam int BIT_STOP  = 2;
  localparam int BIT_START = 1;
  localparam int BIT_INIT  = 0;
  localparam int BIT_IDONE = 8;

  localparam logic [DATA_W-1:0] STICKY_MASK = 16'h7F00;
  localparam logic [DATA_W-1:0] ERR_SRC     = 16'h7100;
  localparam logic [DATA_W-1:0] STOPPED_VAL = 16'h0004;

  localparam int PORT_DATA = 0;
  localparam int PORT_PTR  = 1;

  typedef struct packed {
    logic csrWr;
    logic lowWr;
    logic highWr;
    logic modeWr;
  } strobe_t;
endpackage

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NREGS  = 4,
  localparam int PTR_W = $clog2(NREGS),
  localparam int IDX_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output strobe_t           strobes,
  output logic [PTR_W-1:0]  ptrQ,
  output logic              selData,
  output logic              selPtr
);
  logic [IDX_W-1:0] wordIdx;
  logic             ptrLoad;

  assign wordIdx = busAddr[ADDR_W-1:1];
  assign selData = (wordIdx == IDX_W'(PORT_DATA));
  assign selPtr  = (wordIdx == IDX_W'(PORT_PTR));
  assign ptrLoad = wrEn && selPtr && ({16'b0, wrData} < 32'(NREGS));

  always_ff @(posedge clk) begin
    if (!rstN) ptrQ <= '0;
    else if (ptrLoad) ptrQ <= wrData[PTR_W-1:0];
  end

  always_comb begin
    strobes        = '0;
    strobes.csrWr  = wrEn && selData && (ptrQ == PTR_W'(0));
    strobes.lowWr  = wrEn && selData && (ptrQ == PTR_W'(1));
    strobes.highWr = wrEn && selData && (ptrQ == PTR_W'(2));
    strobes.modeWr = wrEn && selData && (ptrQ == PTR_W'(3));
  end
endmodule

// File: rtl/nic_csr_dp.sv
module nic_csr_dp
  import nic_csr_pkg::*;
#(
  parameter int NREGS  = 4,
  localparam int PTR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic [EVT_W-1:0]  evtSet,
  input  logic [PTR_W-1:0]  ptrQ,
  input  logic              selData,
  input  logic              selPtr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] ctrlStatus,
  output logic [2*DATA_W-1:0] initPtr,
  output logic              irq
);
  logic [DATA_W-1:0] csrQ, lowQ, highQ, modeQ;
  logic [DATA_W-1:0] csrNext, afterWr;

  // next value of the control/status word
  always_comb begin
    afterWr = csrQ & ~(wrData & STICKY_MASK);
    afterWr[BIT_ERR]   = |(afterWr & ERR_SRC);
    afterWr[BIT_IFLAG] = |(afterWr & STICKY_MASK);
    afterWr[BIT_IEN]   = wrData[BIT_IEN];
    if (wrData[BIT_INIT]) begin
      afterWr[BIT_IDONE] = 1'b1;
      afterWr[BIT_INIT]  = 1'b1;
      afterWr[BIT_STOP]  = 1'b0;
    end else if (wrData[BIT_START]) begin
      afterWr[BIT_START] = 1'b1;
      afterWr[BIT_RXON]  = 1'b1;
      afterWr[BIT_TXON]  = 1'b1;
      afterWr[BIT_STOP]  = 1'b0;
    end

    csrNext = csrQ;
    if (strobes.csrWr) csrNext = wrData[BIT_STOP] ? STOPPED_VAL : afterWr;
    if (|evtSet) begin
      csrNext[BIT_IDONE +: EVT_W] = csrNext[BIT_IDONE +: EVT_W] | evtSet;
      csrNext[BIT_IFLAG] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csrQ  <= STOPPED_VAL;
      lowQ  <= '0;
      highQ <= '0;
      modeQ <= '0;
    end else begin
      csrQ <= csrNext;
      if (strobes.lowWr)  lowQ  <= wrData;
      if (strobes.highWr) highQ <= wrData;
      if (strobes.modeWr) modeQ <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (selData) begin
      case (ptrQ)
        PTR_W'(0): rdData = csrQ;
        PTR_W'(1): rdData = lowQ;
        PTR_W'(2): rdData = highQ;
        PTR_W'(3): rdData = modeQ;
        default:   rdData = '0;
      endcase
    end else if (selPtr) begin
      rdData = {{(DATA_W-PTR_W){1'b0}}, ptrQ};
    end
  end

  assign ctrlStatus = csrQ;
  assign initPtr    = {highQ, lowQ};
  assign irq        = csrQ[BIT_IFLAG] & csrQ[BIT_IEN];
endmodule

// File: rtl/nic_csr_window.sv
module nic_csr_window
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NREGS  = 4,
  localparam int PTR_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              wrEn,
  input  logic [15:0]       wrData,
  input  logic [6:0]        evtSet,
  output logic [15:0]       rdData,
  output logic [15:0]       ctrlStatus,
  output logic [31:0]       initPtr,
  output logic              irq
);
  strobe_t          strobes;
  logic [PTR_W-1:0] ptrCur;
  logic             selData, selPtr;

  nic_csr_ctrl #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .strobes(strobes), .ptrQ(ptrCur), .selData(selData), .selPtr(selPtr)
  );

  nic_csr_dp #(.NREGS(NREGS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData), .evtSet(evtSet),
    .ptrQ(ptrCur), .selData(selData), .selPtr(selPtr), .rdData(rdData),
    .ctrlStatus(ctrlStatus), .initPtr(initPtr), .irq(irq)
  );
endmodule

// File: rtl/nic_csr_chk.sv
module nic_csr_chk #(
  parameter int ADDR_W = 3,
  parameter int NREGS  = 4,
  localparam int PTR_W = $clog2(NREGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              wrEn,
  input logic [15:0]       wrData,
  input logic [6:0]        evtSet,
  input logic [15:0]       ctrlStatus,
  input logic [31:0]       initPtr,
  input logic              irq,
  input logic [PTR_W-1:0]  ptrCur
);
  logic [ADDR_W-2:0] wIdx;
  logic              csrWrite;
  assign wIdx     = busAddr[ADDR_W-1:1];
  assign csrWrite = wrEn && (wIdx == 0) && (ptrCur == 0);

  p_ignore_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wIdx > 1 && evtSet == 0) |=> ($stable(ctrlStatus) && $stable(initPtr) && $stable(ptrCur)));

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wIdx == 1 && {16'b0, wrData} >= 32'(NREGS)) |=> $stable(ptrCur));

  p_stop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && wrData[2] && evtSet == 0) |=> (ctrlStatus == 16'h0004));

  p_ien_r6: assert property (@(posedge clk) disable iff (!rstN)
    (csrWrite && !wrData[2]) |=> (ctrlStatus[6] == $past(wrData[6])));

  p_low_half_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wIdx == 0 && ptrCur == 1) |=> (initPtr[15:0] == $past(wrData)));

  p_irq_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlStatus[7] && ctrlStatus[6]));

  p_event_r12: assert property (@(posedge clk) disable iff (!rstN)
    (evtSet != 0) |=> ctrlStatus[7]);
endmodule

bind nic_csr_window nic_csr_chk #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
  .evtSet(evtSet), .ctrlStatus(ctrlStatus), .initPtr(initPtr), .irq(irq),
  .ptrCur(ptrCur)
);

// File: tb/test_nic_csr_window.sv
module test_nic_csr_window;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [6:0]  evtSet = '0;
  logic [15:0] rdData, ctrlStatus;
  logic [31:0] initPtr;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  logic sampleReq = 1'b0;
  bit   done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdData, 1 ctrlStatus, 2 initPtr, 3 irq
    logic [31:0] val;
    string       tag;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  nic_csr_window i_nic_csr_window (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .wrEn(wrEn), .wrData(wrData),
    .evtSet(evtSet), .rdData(rdData), .ctrlStatus(ctrlStatus),
    .initPtr(initPtr), .irq(irq)
  );

  // monitor: compares on the falling edge
  always @(negedge clk) begin
    if (sampleReq && expQ.size() > 0) begin
      item_t it;
      logic [31:0] got;
      it = expQ.pop_front();
      case (it.kind)
        0: got = {16'b0, rdData};
        1: got = {16'b0, ctrlStatus};
        2: got = initPtr;
        default: got = {31'b0, irq};
      endcase
      nChecks++;
      if (got !== it.val) begin
        nFails++;
        $display("FAIL %s: kind %0d got %h expected %h", it.tag, it.kind, got, it.val);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(posedge clk); #1;
    evtSet = e;
    @(posedge clk); #1;
    evtSet = '0;
  endtask

  task automatic expect_val(input int kind, input logic [2:0] a,
                            input logic [31:0] v, input string tag);
    item_t it;
    @(posedge clk); #1;
    busAddr = a; wrEn = 1'b0;
    it.kind = kind; it.val = v; it.tag = tag;
    expQ.push_back(it);
    sampleReq = 1'b1;
    @(negedge clk); #1;
    sampleReq = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10 reset state
    expect_val(1, 3'd0, 32'h0004, "R10 csr");
    expect_val(3, 3'd0, 32'h0,    "R10 irq");
    expect_val(2, 3'd0, 32'h0,    "R10 initPtr");
    expect_val(0, 3'd2, 32'h0,    "R10 ptr");
    // R7 INIT; R5 summary not including new bit 8
    wr(3'd0, 16'h0001);
    expect_val(1, 3'd0, 32'h0101, "R7 init / R5 deferred");
    // R5 R6 R11
    wr(3'd0, 16'h0040);
    expect_val(1, 3'd0, 32'h81C1, "R5 R6 summary and enable");
    expect_val(3, 3'd0, 32'h1,    "R11 irq high");
    // R4 clear bit 8
    wr(3'd0, 16'h0100);
    expect_val(0, 3'd0, 32'h0001, "R4 clear idone");
    expect_val(3, 3'd0, 32'h0,    "R11 irq low");
    // R7 INIT over START
    wr(3'd0, 16'h0003);
    expect_val(1, 3'd0, 32'h0101, "R7 priority");
    // R3 STOP overrides
    wr(3'd0, 16'h0006);
    expect_val(1, 3'd0, 32'h0004, "R3 stop");
    wr(3'd0, 16'h0002);
    expect_val(1, 3'd0, 32'h0032, "R7 start");
    // R12 events
    pulse(7'b0000010);
    expect_val(1, 3'd0, 32'h02B2, "R12 event bit9");
    pulse(7'b0010000);
    expect_val(1, 3'd0, 32'h12B2, "R12 event bit12 no err yet");
    wr(3'd0, 16'h0040);
    expect_val(1, 3'd0, 32'h92F2, "R5 error summary");
    wr(3'd0, 16'h1040);
    expect_val(1, 3'd0, 32'h02F2, "R4 R5 partial clear");
    expect_val(3, 3'd0, 32'h1,    "R11 irq");
    // R8 pointer halves
    wr(3'd2, 16'h0001);
    wr(3'd0, 16'hBEEF);
    expect_val(2, 3'd0, 32'h0000BEEF, "R8 low half");
    expect_val(0, 3'd0, 32'hBEEF,     "R8 read low");
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h1234);
    expect_val(2, 3'd0, 32'h1234BEEF, "R8 full pointer");
    // R9 mode word
    wr(3'd2, 16'h0003);
    wr(3'd0, 16'hA5C3);
    expect_val(0, 3'd0, 32'hA5C3, "R9 mode read");
    expect_val(1, 3'd0, 32'h02F2, "R9 csr untouched");
    // R2 out-of-range pointer
    wr(3'd2, 16'h0004);
    expect_val(0, 3'd2, 32'h0003, "R2 ptr hold 4");
    wr(3'd2, 16'hFFFF);
    expect_val(0, 3'd2, 32'h0003, "R2 ptr hold ffff");
    // R1 other words ignored and read zero
    wr(3'd4, 16'hFFFF);
    wr(3'd6, 16'h0000);
    expect_val(0, 3'd4, 32'h0, "R1 word2 reads 0");
    expect_val(0, 3'd6, 32'h0, "R1 word3 reads 0");
    expect_val(0, 3'd0, 32'hA5C3, "R1 mode unchanged");
    expect_val(1, 3'd0, 32'h02F2, "R1 csr unchanged");
    expect_val(2, 3'd0, 32'h1234BEEF, "R1 initPtr unchanged");
    expect_val(0, 3'd3, 32'h0003, "R1 byte bit ignored");
    // R3 stop clears everything including enable
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'hFF47);
    expect_val(1, 3'd0, 32'h0004, "R3 stop with all bits");
    expect_val(3, 3'd0, 32'h0,    "R11 irq after stop");
    done = 1'b1;
    summary();
  end
endmodule